// File: doc/BRIEF.md
# Twelve-Sector Medium-Vector Toggle Selector

This block picks the switching vectors that a pair of three-phase inverters driving a dual three-phase machine applies in each PWM period. It receives a signed alpha-beta voltage reference and the signed dwell time that an upstream calculator has computed for the first category of medium vector. From these it finds which of twelve fixed 30° sectors holds the reference. It then reports the three large vectors of that sector and the medium vector, or the pair of medium vectors, to apply. The sector borders are the medium-vector directions, and these do not move when the two DC links are unbalanced. The medium vector is swapped to its opposite category whenever its computed dwell goes negative. The upstream calculator derives that dwell from the DC-link voltage ratio, so the swap point depends only on the ratio and not on the reference magnitude.

A vector code is six bits, written {A1,B1,C1,A2,B2,C2}, with 1 meaning the upper switch of that leg is on. Set 2 legs sit 30° ahead of set 1, so the legs lie at A1 0°, A2 30°, B1 120°, B2 150°, C1 240° and C2 270°. In this document, the direction of a code is the angle of the sum of unit phasors at the positions of its set bits. All outputs are captured together on a period-start strobe, so nothing changes in the middle of a period.

Top module: `medvec_sector_sel`

## Requirements
- R1: While reset is held, and after it until the first strobe, sector reads 0 and every vector code, the type flag and the per-vector dwell read 0.
- R2: Outputs change only at a rising clock edge where pwm_start is high; at all other edges every output holds its value, whatever the other inputs do.
- R3: For a reference strictly inside the angular interval ((k-1)·30°, k·30°), the sector output is k, for k = 1..12, independent of reference magnitude.
- R4: References on an axis map as follows: +alpha to sector 1, +beta to sector 4, -alpha to sector 7 and -beta to sector 10. A zero reference maps to sector 1.
- R5: The large-vector outputs vec_l0, vec_l1 and vec_l2 point at S-15°, S+15° and S+45°, where S = (sector-1)·30°. In sector 1 they are 37, 36 and 52.
- R6: A medium dwell of zero or more selects the first category (med_type2 = 0). A negative dwell selects the second category (med_type2 = 1).
- R7: In single mode (dual_mode = 0), vec_m0 points at S for the first category (39 in sector 1) and at S+30° for the second category (60 in sector 1), and vec_m1 is 0.
- R8: In dual mode, vec_m0 is chosen as in R7. vec_m1 points at S+60° for the first category (48 in sector 1) and at S-30° for the second category (5 in sector 1).
- R9: t_med_each equals |t_med| in single mode and floor(|t_med|/2) in dual mode, and this also holds for the most negative input.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_start | input | 1 | Period-start strobe; outputs capture on this edge |
| dual_mode | input | 1 | 0: one medium vector, 1: a pair sharing the medium time |
| v_alpha | input | REF_W | Signed alpha reference |
| v_beta | input | REF_W | Signed beta reference |
| t_med | input | TIME_W | Signed computed dwell of the first medium category |
| sector | output | 4 | Sector index 1..12, 0 before first strobe |
| vec_l0 | output | 6 | Large vector at S-15° |
| vec_l1 | output | 6 | Large vector at S+15° |
| vec_l2 | output | 6 | Large vector at S+45° |
| vec_m0 | output | 6 | First medium vector |
| vec_m1 | output | 6 | Second medium vector (0 in single mode) |
| med_type2 | output | 1 | 1 when the second medium category is in use |
| t_med_each | output | TIME_W | Dwell per medium vector |

## Verification
A sector change and a medium-category toggle can land on the same strobe. The bench provokes this by moving the reference to a new sector while flipping the sign of t_med, sometimes also switching dual_mode on that strobe. Each capture is judged by recomputing, from the reference angle, the expected sector and the direction of every returned code by phasor summation. The hold rule is judged on the following idle edge, where the inputs are changed with the strobe low.

// File: rtl/medvec_sector_sel.sv
module medvec_sector_sel #(
  parameter int REF_W  = 16,
  parameter int TIME_W = 16,
  parameter int FRAC_W = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     pwm_start,
  input  logic                     dual_mode,
  input  logic signed [REF_W-1:0]  v_alpha,
  input  logic signed [REF_W-1:0]  v_beta,
  input  logic signed [TIME_W-1:0] t_med,
  output logic [3:0]               sector,
  output logic [5:0]               vec_l0,
  output logic [5:0]               vec_l1,
  output logic [5:0]               vec_l2,
  output logic [5:0]               vec_m0,
  output logic [5:0]               vec_m1,
  output logic                     med_type2,
  output logic [TIME_W-1:0]        t_med_each
);

  localparam int    PROD_W = REF_W + FRAC_W + 2;
  localparam longint K30   = longint'($rtoi(0.5773502691896258 * (2.0 ** FRAC_W)));
  localparam longint K60   = longint'($rtoi(1.7320508075688772 * (2.0 ** FRAC_W)));
  localparam logic [5:0] BASE [7] = '{6'd37, 6'd36, 6'd52, 6'd39, 6'd48, 6'd60, 6'd5};

  function automatic logic [5:0] rot_n(input logic [5:0] c, input int n);
    logic [5:0] r;
    r = c;
    for (int i = 0; i < n; i++) r = {~r[1], ~r[0], ~r[2], r[5], r[4], r[3]};
    return r;
  endfunction

  logic [5:0] lut [12][7];
  for (genvar k = 0; k < 12; k++) begin : g_sec
    for (genvar j = 0; j < 7; j++) begin : g_vec
      assign lut[k][j] = rot_n(BASE[j], k);
    end
  end

  logic [REF_W-1:0]  a_mag, b_mag;
  logic [PROD_W-1:0] a30, a60, b_sh;
  logic [1:0]        reg30;
  logic [3:0]        sec_nx, idx;
  logic              typ2_nx;
  logic [TIME_W-1:0] t_mag;

  assign a_mag = v_alpha[REF_W-1] ? REF_W'(-v_alpha) : REF_W'(v_alpha);
  assign b_mag = v_beta[REF_W-1]  ? REF_W'(-v_beta)  : REF_W'(v_beta);
  assign a30   = PROD_W'(a_mag) * PROD_W'(K30);
  assign a60   = PROD_W'(a_mag) * PROD_W'(K60);
  assign b_sh  = PROD_W'(b_mag) << FRAC_W;
  assign reg30 = (b_sh < a30) ? 2'd0 : (b_sh < a60) ? 2'd1 : 2'd2;

  always_comb begin
    if (v_alpha > 0 && v_beta >= 0)       sec_nx = 4'd1  + {2'b0, reg30};
    else if (v_alpha <= 0 && v_beta > 0)  sec_nx = 4'd6  - {2'b0, reg30};
    else if (v_alpha < 0 && v_beta <= 0)  sec_nx = 4'd7  + {2'b0, reg30};
    else if (v_alpha >= 0 && v_beta < 0)  sec_nx = 4'd12 - {2'b0, reg30};
    else                                  sec_nx = 4'd1;
  end

  assign idx     = sec_nx - 4'd1;
  assign typ2_nx = t_med[TIME_W-1];
  assign t_mag   = typ2_nx ? TIME_W'(-t_med) : TIME_W'(t_med);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sector     <= '0;
      vec_l0     <= '0;
      vec_l1     <= '0;
      vec_l2     <= '0;
      vec_m0     <= '0;
      vec_m1     <= '0;
      med_type2  <= 1'b0;
      t_med_each <= '0;
    end else if (pwm_start) begin
      sector     <= sec_nx;
      vec_l0     <= lut[idx][0];
      vec_l1     <= lut[idx][1];
      vec_l2     <= lut[idx][2];
      vec_m0     <= typ2_nx ? lut[idx][5] : lut[idx][3];
      vec_m1     <= !dual_mode ? 6'd0 : (typ2_nx ? lut[idx][6] : lut[idx][4]);
      med_type2  <= typ2_nx;
      t_med_each <= dual_mode ? (t_mag >> 1) : t_mag;
    end
  end

  a_r2_hold_between_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !pwm_start |=> $stable(sector) && $stable(vec_m0) && $stable(vec_m1) && $stable(t_med_each));

  a_r3_sector_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start |=> (sector >= 4'd1 && sector <= 4'd12));

  a_r6_type_follows_sign: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start |=> med_type2 == $past(t_med < 0));

  a_r7_single_no_second: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start && !dual_mode |=> vec_m1 == 6'd0);

  a_r5_codes_distinct: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start |=> vec_m0 != vec_l0 && vec_m0 != vec_l1 && vec_m0 != vec_l2 && vec_l0 != vec_l2);

  a_r9_dual_halved: assert property (@(posedge clk) disable iff (!rst_n)
    pwm_start && dual_mode |=> t_med_each[TIME_W-1] == 1'b0);

endmodule

// File: tb/tb_medvec_sector_sel.sv
module tb_medvec_sector_sel;
  localparam int CLK_P  = 10;
  localparam int REF_W  = 16;
  localparam int TIME_W = 16;

  logic clk = 1'b0, rst_n = 1'b0, pwm_start = 1'b0, dual_mode = 1'b0;
  logic signed [REF_W-1:0]  v_alpha = '0, v_beta = '0;
  logic signed [TIME_W-1:0] t_med = '0;
  logic [3:0] sector;
  logic [5:0] vec_l0, vec_l1, vec_l2, vec_m0, vec_m1;
  logic med_type2;
  logic [TIME_W-1:0] t_med_each;

  medvec_sector_sel #(.REF_W(REF_W), .TIME_W(TIME_W), .FRAC_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .pwm_start(pwm_start), .dual_mode(dual_mode),
    .v_alpha(v_alpha), .v_beta(v_beta), .t_med(t_med), .sector(sector),
    .vec_l0(vec_l0), .vec_l1(vec_l1), .vec_l2(vec_l2), .vec_m0(vec_m0),
    .vec_m1(vec_m1), .med_type2(med_type2), .t_med_each(t_med_each));

  always #(CLK_P/2) clk = ~clk;

  typedef struct {
    int  sec;
    bit  typ2;
    bit  dual;
    int  teach;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0, n_bad = 0;
  int last_sec = 0;
  bit have_last = 0, done = 0;

  task automatic check(bit ok, string req, string what, int got, int expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, got, expv);
    end
  endtask

  function automatic real code_deg(input logic [5:0] c);
    real x, y, d;
    real pos [6] = '{270.0, 150.0, 30.0, 240.0, 120.0, 0.0};
    x = 0.0; y = 0.0;
    for (int i = 0; i < 6; i++)
      if (c[i]) begin
        x += $cos(pos[i] * 3.141592653589793 / 180.0);
        y += $sin(pos[i] * 3.141592653589793 / 180.0);
      end
    d = $atan2(y, x) * 180.0 / 3.141592653589793;
    if (d < 0.0) d += 360.0;
    return d;
  endfunction

  function automatic bit dir_ok(input logic [5:0] c, input real want);
    real d;
    if (c == 6'd0 || c == 6'd63) return 0;
    d = code_deg(c) - want;
    while (d > 180.0) d -= 360.0;
    while (d <= -180.0) d += 360.0;
    return (d < 1.0 && d > -1.0);
  endfunction

  task automatic send_raw(int a, int b, int tm, bit dm);
    exp_t e;
    real ang;
    int mag;
    ang = $atan2(real'(b), real'(a)) * 180.0 / 3.141592653589793;
    if (ang < 0.0) ang += 360.0;
    ang += 1.0e-6;
    if (ang >= 360.0) ang -= 360.0;
    e.sec   = int'($floor(ang / 30.0)) + 1;
    e.typ2  = (tm < 0);
    e.dual  = dm;
    mag     = (tm < 0) ? -tm : tm;
    e.teach = dm ? (mag / 2) : mag;
    @(negedge clk);
    v_alpha = REF_W'(a); v_beta = REF_W'(b); t_med = TIME_W'(tm); dual_mode = dm;
    pwm_start = 1'b1;
    sb.push_back(e);
    @(negedge clk);
    pwm_start = 1'b0;
    v_alpha = REF_W'(-b); v_beta = REF_W'(a); t_med = TIME_W'(-tm); dual_mode = ~dm;
    @(negedge clk);
  endtask

  task automatic send_pol(real deg, real mag, int tm, bit dm);
    send_raw(int'(mag * $cos(deg * 3.141592653589793 / 180.0)),
             int'(mag * $sin(deg * 3.141592653589793 / 180.0)), tm, dm);
  endtask

  initial begin : monitor
    exp_t e;
    real s;
    forever begin
      @(posedge clk);
      if (rst_n && pwm_start) begin
        #(CLK_P/4);
        if (sb.size() == 0) check(0, "R2", "unexpected capture", 0, 1);
        else begin
          e = sb.pop_front();
          s = real'((e.sec - 1) * 30);
          check(sector == e.sec, "R3/R4", "sector", sector, e.sec);
          check(dir_ok(vec_l0, s - 15.0), "R5", "vec_l0", vec_l0, e.sec);
          check(dir_ok(vec_l1, s + 15.0), "R5", "vec_l1", vec_l1, e.sec);
          check(dir_ok(vec_l2, s + 45.0), "R5", "vec_l2", vec_l2, e.sec);
          check(med_type2 == e.typ2, "R6", "med_type2", med_type2, e.typ2);
          check(dir_ok(vec_m0, e.typ2 ? s + 30.0 : s), "R7", "vec_m0", vec_m0, e.sec);
          if (e.dual)
            check(dir_ok(vec_m1, e.typ2 ? s - 30.0 : s + 60.0), "R8", "vec_m1", vec_m1, e.sec);
          else
            check(vec_m1 == 6'd0, "R7", "vec_m1 single", vec_m1, 0);
          check(int'(t_med_each) == e.teach, "R9", "t_med_each", t_med_each, e.teach);
          if (e.sec == 1) begin
            check(vec_l0 == 6'd37 && vec_l1 == 6'd36 && vec_l2 == 6'd52, "R5", "sector-1 large l0", vec_l0, 37);
            check(vec_m0 == (e.typ2 ? 6'd60 : 6'd39), "R7", "sector-1 medium", vec_m0, e.typ2 ? 60 : 39);
            if (e.dual) check(vec_m1 == (e.typ2 ? 6'd5 : 6'd48), "R8", "sector-1 pair", vec_m1, e.typ2 ? 5 : 48);
          end
          last_sec = e.sec;
          have_last = 1;
        end
      end else if (rst_n && have_last) begin
        #(CLK_P/4);
        check(sector == last_sec, "R2", "hold sector", sector, last_sec);
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    #(CLK_P * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check(sector == 4'd0, "R1", "reset sector", sector, 0);
    check(vec_l0 == 0 && vec_l1 == 0 && vec_l2 == 0 && vec_m0 == 0 && vec_m1 == 0,
          "R1", "reset codes", vec_m0, 0);
    check(med_type2 == 1'b0 && t_med_each == '0, "R1", "reset dwell", t_med_each, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check(sector == 4'd0, "R1", "idle after reset", sector, 0);
    for (int k = 0; k < 12; k++) begin
      send_pol(15.0 + 30.0 * k, 20000.0, 1200, 1'b0);
      send_pol(15.0 + 30.0 * k, 20000.0, -1200, 1'b1);
      send_pol(15.0 + 30.0 * k, 900.0, 0, 1'b1);
      send_pol(15.0 + 30.0 * k, 31000.0, -77, 1'b0);
    end
    send_pol(29.0, 15000.0, 5, 1'b0);
    send_pol(31.0, 15000.0, -5, 1'b1);
    send_pol(59.0, 300.0, 7, 1'b1);
    send_pol(301.0, 25000.0, -32768, 1'b1);
    send_pol(181.0, 25000.0, -32768, 1'b0);
    send_raw(1000, 0, 10, 1'b0);
    send_raw(0, 1000, 10, 1'b0);
    send_raw(-1000, 0, -10, 1'b1);
    send_raw(0, -1000, 10, 1'b1);
    send_raw(0, 0, 3, 1'b1);
    send_raw(-32768, 0, 32767, 1'b1);
    repeat (3) @(negedge clk);
    check(sb.size() == 0, "R2", "scoreboard drained", sb.size(), 0);
    finish_run();
  end
endmodule